// File: doc/BRIEF.md
# Fatal/Nonfatal Interrupt Masking Controller

This block gathers single-cycle event pulses from a bus protocol engine (the SCSI group) and from a DMA engine (the DMA group) into sticky status bits. When an event arrives, the block also decides whether it is fatal or nonfatal. Fatal events stop the instruction sequencer. Nonfatal events let it keep running. The decision depends on the event and on whether the engine is acting as initiator or as target.

Each event has an enable bit, and the enable bit controls only whether the event may pull the interrupt pin low. A masked event still records its status bit. A masked fatal event still halts the sequencer and still raises its group's summary bit. A masked nonfatal event records status and does nothing else.

Software reads a status word to clear it. After clearing the fatal status, software issues a restart strobe to release the halt.

Top module: `intm_ctrl`

## Requirements
- R1: Every event pulse sets its status bit on the next clock edge, whether or not its enable is set.
- R2: SCSI events 8 (handshake-timer expiry), 9 (general-timer expiry) and 11 (on-the-fly sequencer event) are nonfatal in both modes.
- R3: SCSI events 4 to 7 (reselected, selected, arbitration complete, attention raised by initiator) are nonfatal when `tgt_mode` is 1 and fatal when it is 0.
- R4: All other SCSI events (0-3, 10, 12-15) and all eight DMA events are fatal in both modes.
- R5: A fatal event raises `halt_req` on the next clock edge, whatever its enable.
- R6: A masked nonfatal event leaves `halt_req` low, its summary bit low and `irq_n` high.
- R7: A masked fatal event raises its group's summary bit (`scsi_pend` or `dma_pend`) and leaves `irq_n` high.
- R8: `irq_n` is low exactly while some status bit with its enable set is pending. An enabled pending bit also holds its group's summary bit high.
- R9: A read with `rd_en`=1 returns the selected word combinationally on `rd_data`. `rd_sel` 0 selects SCSI bits 7:0, 1 selects SCSI bits 15:8, 2 selects DMA bits 7:0, and 3 returns zero. The read clears only that word, on the next edge.
- R10: An event that arrives in the same cycle as a clear of its word stays set.
- R11: `halt_req` stays high until a `restart` arrives while no fatal status bit is pending. A restart that arrives earlier is ignored.
- R12: Fatality is fixed when the event is recorded. A later change of `tgt_mode` does not turn a pending nonfatal bit into a fatal one.
- R13: After reset all status is zero, `halt_req` is 0, both summary bits are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_mode | input | 1 | 1 = target operation, 0 = initiator |
| scsi_evt | input | 16 | SCSI event pulses |
| dma_evt | input | 8 | DMA event pulses |
| scsi_en_lo | input | 8 | Enables for SCSI events 7:0 |
| scsi_en_hi | input | 8 | Enables for SCSI events 15:8 |
| dma_en | input | 8 | Enables for DMA events |
| rd_en | input | 1 | Read-to-clear strobe |
| rd_sel | input | 2 | Status word select |
| rd_data | output | 8 | Selected status word |
| restart | input | 1 | Sequencer restart strobe |
| halt_req | output | 1 | Halt request to the sequencer |
| scsi_pend | output | 1 | SCSI group summary pending |
| dma_pend | output | 1 | DMA group summary pending |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions run on every cycle and check four things:
- each event is captured, including an event that collides with a clear;
- a fatal event is followed by a halt;
- the halt never drops while fatal status is still pending, nor without a restart;
- a low pin always has a summary bit behind it.

Three behaviours need the bench's scenarios instead:
- the per-event fatal/nonfatal classification in each mode;
- the read-word select encoding and the isolation between words;
- fatality staying fixed after a change of mode.

// File: rtl/intm_pkg.sv
package intm_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    SEL_SCSI_LO = 2'd0,
    SEL_SCSI_HI = 2'd1,
    SEL_DMA     = 2'd2,
    SEL_NONE    = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/intm_classify.sv
module intm_classify #(
  parameter int          W        = 16,
  parameter logic [W-1:0] ALWAYS_NF = '0,
  parameter logic [W-1:0] TGT_NF    = '0
) (
  input  logic         tgt_mode,
  output logic [W-1:0] fatal
);
  // A bit is fatal unless it is listed as nonfatal for the current mode.
  function automatic logic [W-1:0] fatal_of(input logic tgt);
    logic [W-1:0] nf;
    nf = ALWAYS_NF | (tgt ? TGT_NF : '0);
    return ~nf;
  endfunction

  assign fatal = fatal_of(tgt_mode);
endmodule

// File: rtl/intm_status_bank.sv
module intm_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] fatal,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat,
  output logic [W-1:0] fat
);
  logic [W-1:0] stat_q, fat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      fat_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      fat_q  <= (fat_q & ~clr) | (evt & fatal);
    end
  end

  assign stat = stat_q;
  assign fat  = fat_q;

  // R1: any event is captured in its status bit
  a_r1_evt_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R10: an event colliding with a clear survives
  a_r10_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & clr)) |=> ((stat & $past(evt & clr)) == $past(evt & clr)));
endmodule

// File: rtl/intm_halt_ctl.sv
module intm_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fatal_hit,
  input  logic fatal_pending,
  input  logic restart,
  output logic halt_req
);
  logic halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      halt_q <= 1'b0;
    else if (fatal_hit)
      halt_q <= 1'b1;
    else if (restart && !fatal_pending)
      halt_q <= 1'b0;
  end

  assign halt_req = halt_q;

  // R5: a fatal event halts the sequencer
  a_r5_fatal_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_hit |=> halt_req);

  // R11: halt is held while fatal status remains
  a_r11_hold_while_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && fatal_pending) |=> halt_req);

  // R11: halt only drops after a restart
  a_r11_release_needs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> $past(restart));
endmodule

// File: rtl/intm_ctrl.sv
module intm_ctrl
  import intm_pkg::*;
#(
  parameter int DMA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tgt_mode,
  input  logic [2*WORD_W-1:0] scsi_evt,
  input  logic [DMA_W-1:0]    dma_evt,
  input  logic [WORD_W-1:0]   scsi_en_lo,
  input  logic [WORD_W-1:0]   scsi_en_hi,
  input  logic [DMA_W-1:0]    dma_en,
  input  logic                rd_en,
  input  logic [1:0]          rd_sel,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                restart,
  output logic                halt_req,
  output logic                scsi_pend,
  output logic                dma_pend,
  output logic                irq_n
);
  localparam int SCSI_W = 2 * WORD_W;
  // Timer expiries (8, 9) and on-the-fly (11) never halt.
  localparam logic [SCSI_W-1:0] SCSI_ALWAYS_NF = SCSI_W'(16'h0B00);
  // Reselect, select, arbitration done, attention: nonfatal as target.
  localparam logic [SCSI_W-1:0] SCSI_TGT_NF    = SCSI_W'(16'h00F0);

  logic [SCSI_W-1:0] scsi_fatal, scsi_clr, scsi_stat, scsi_fat, scsi_en;
  logic [DMA_W-1:0]  dma_fatal, dma_clr, dma_stat, dma_fat;
  logic              fatal_hit, fatal_pending;
  rd_sel_e           sel;

  assign sel     = rd_sel_e'(rd_sel);
  assign scsi_en = {scsi_en_hi, scsi_en_lo};

  intm_classify #(.W(SCSI_W), .ALWAYS_NF(SCSI_ALWAYS_NF), .TGT_NF(SCSI_TGT_NF))
    u_cls_scsi (.tgt_mode(tgt_mode), .fatal(scsi_fatal));

  intm_classify #(.W(DMA_W), .ALWAYS_NF('0), .TGT_NF('0))
    u_cls_dma (.tgt_mode(tgt_mode), .fatal(dma_fatal));

  always_comb begin
    scsi_clr = '0;
    dma_clr  = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_SCSI_LO: scsi_clr[WORD_W-1:0]      = '1;
        SEL_SCSI_HI: scsi_clr[SCSI_W-1:WORD_W] = '1;
        SEL_DMA:     dma_clr                   = '1;
        default:     ;
      endcase
    end
  end

  intm_status_bank #(.W(SCSI_W)) u_bank_scsi (
    .clk(clk), .rst_n(rst_n), .evt(scsi_evt), .fatal(scsi_fatal),
    .clr(scsi_clr), .stat(scsi_stat), .fat(scsi_fat));

  intm_status_bank #(.W(DMA_W)) u_bank_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .fatal(dma_fatal),
    .clr(dma_clr), .stat(dma_stat), .fat(dma_fat));

  always_comb begin
    unique case (sel)
      SEL_SCSI_LO: rd_data = scsi_stat[WORD_W-1:0];
      SEL_SCSI_HI: rd_data = scsi_stat[SCSI_W-1:WORD_W];
      SEL_DMA:     rd_data = WORD_W'(dma_stat);
      default:     rd_data = '0;
    endcase
  end

  assign fatal_hit     = |(scsi_evt & scsi_fatal) | |(dma_evt & dma_fatal);
  assign fatal_pending = |scsi_fat | |dma_fat;

  intm_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .fatal_hit(fatal_hit),
    .fatal_pending(fatal_pending), .restart(restart), .halt_req(halt_req));

  assign scsi_pend = |(scsi_stat & (scsi_en | scsi_fat));
  assign dma_pend  = |(dma_stat & (dma_en | dma_fat));
  assign irq_n     = ~(|(scsi_stat & scsi_en) | |(dma_stat & dma_en));

  // R8: a low pin is always backed by a summary bit
  a_r8_pin_has_summary: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (scsi_pend || dma_pend));

  // R13: out of reset the pin is quiet
  a_r13_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (irq_n && !halt_req));
endmodule

// File: tb/intm_ctrl_tb.sv
`timescale 1ns/1ps
module intm_ctrl_tb;
  logic        clk = 0, rst_n = 0, tgt_mode = 0;
  logic [15:0] scsi_evt = 0;
  logic [7:0]  dma_evt = 0, scsi_en_lo = 0, scsi_en_hi = 0, dma_en = 0;
  logic        rd_en = 0, restart = 0;
  logic [1:0]  rd_sel = 0;
  logic [7:0]  rd_data;
  logic        halt_req, scsi_pend, dma_pend, irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intm_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Own model of fatality: nonfatal set is {8,9,11}, plus {4..7} as target.
  function automatic bit is_fatal(input int b, input bit tgt);
    if (b == 8 || b == 9 || b == 11) return 0;
    if (tgt && b >= 4 && b <= 7) return 0;
    return 1;
  endfunction

  task automatic pulse(input logic [15:0] s, input logic [7:0] d);
    @(negedge clk); scsi_evt = s; dma_evt = d;
    @(negedge clk); scsi_evt = 0; dma_evt = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk); rd_en = 1; rd_sel = sel; #0.5 val = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(0, v); rd(1, v); rd(2, v); do_restart();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R13 halt", halt_req, 0); chk("R13 irq_n", irq_n, 1);
    chk("R13 pend", {scsi_pend, dma_pend}, 0);
    rd(0, v); chk("R13 word0", v, 0);
    rd(2, v); chk("R13 dma", v, 0);
  endtask

  task automatic t_masked_nonfatal();
    logic [7:0] v;
    tgt_mode = 1; pulse(16'h0020, 0);
    chk("R6 halt", halt_req, 0); chk("R6 pend", scsi_pend, 0); chk("R6 irq_n", irq_n, 1);
    rd(0, v); chk("R1 masked status R9 read", v, 8'h20);
    rd(0, v); chk("R9 cleared", v, 0);
  endtask

  task automatic t_enabled_nonfatal();
    logic [7:0] v;
    tgt_mode = 0; scsi_en_hi = 8'h02; pulse(16'h0200, 0);
    chk("R2/R8 pend", scsi_pend, 1); chk("R8 irq_n", irq_n, 0); chk("R2 halt", halt_req, 0);
    rd(1, v); chk("R9 hi word", v, 8'h02);
    chk("R8 irq released", irq_n, 1); scsi_en_hi = 0;
  endtask

  task automatic t_masked_fatal();
    logic [7:0] v;
    tgt_mode = 0; pulse(16'h0020, 0);
    chk("R3/R5 halt", halt_req, 1); chk("R7 pend", scsi_pend, 1); chk("R7 irq_n", irq_n, 1);
    do_restart(); chk("R11 early restart ignored", halt_req, 1);
    rd(0, v); chk("R11 halt held after clear", halt_req, 1);
    do_restart(); chk("R11 released", halt_req, 0);
    chk("R7 pend cleared", scsi_pend, 0);
  endtask

  task automatic t_dma_fatal();
    logic [7:0] v;
    tgt_mode = 1; dma_en = 8'h04; pulse(0, 8'h04);
    chk("R4 dma halt", halt_req, 1); chk("R8 dma pend", dma_pend, 1); chk("R8 irq_n", irq_n, 0);
    chk("R7 scsi pend quiet", scsi_pend, 0);
    rd(2, v); chk("R9 dma word", v, 8'h04);
    do_restart(); chk("R11 dma released", halt_req, 0); dma_en = 0;
  endtask

  task automatic t_mode_fixed();
    tgt_mode = 1; pulse(16'h0040, 0);
    tgt_mode = 0; @(negedge clk);
    chk("R12 halt", halt_req, 0); chk("R12 pend", scsi_pend, 0);
    clear_all();
  endtask

  task automatic t_collision();
    logic [7:0] v;
    pulse(16'h0008, 0);
    pulse(16'h0100, 0);
    @(negedge clk); rd_en = 1; rd_sel = 0; scsi_evt = 16'h0001;
    @(negedge clk); rd_en = 0; scsi_evt = 0;
    rd(0, v); chk("R10 collision", v, 8'h01);
    rd(1, v); chk("R9 other word kept", v, 8'h01);
    do_restart(); chk("R11 collided cleared", halt_req, 0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 16; b++) begin
        tgt_mode = m[0];
        pulse(16'(1) << b, 0);
        chk($sformatf("R2/R3/R4 bit %0d mode %0d halt", b, m), halt_req, 16'(is_fatal(b, m[0])));
        chk($sformatf("R6/R7 bit %0d mode %0d pend", b, m), scsi_pend, 16'(is_fatal(b, m[0])));
        clear_all();
      end
    end
    for (int b = 0; b < 8; b++) begin
      pulse(0, 8'(1) << b);
      chk($sformatf("R4 dma bit %0d", b), halt_req, 1);
      clear_all();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_nonfatal();
    t_enabled_nonfatal();
    t_masked_fatal();
    t_dma_fatal();
    t_mode_fixed();
    t_collision();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule